// File: doc/BRIEF.md
# Transmit Monitor Interrupt Collector

This block collects completion events from sixteen transmit monitor channels. The channels are grouped as eight channels on each of two time-division multiplexes. Each channel can report three kinds of event as single-cycle pulses:

- a word was sent and pre-acknowledged, so the transmit data holding register is free again;
- the remote receiver aborted the message;
- the channel's one-millisecond timer expired.

Any of these events sets that channel's bit in a 16-bit status word. The bit stays set until a processor read. A read returns the word and clears it.

Each channel has a timer. The timer starts again whenever a word is loaded for transmission. It advances on a shared clock-enable tick. It stops when the word is acknowledged or aborted. After a set number of ticks it raises a timeout event, and that event sets the status bit only while timeout reporting is enabled.

A single summary interrupt, registered and maskable, tells the system interrupt controller that at least one status bit is set.

Top module: `mon_irq_collector`

## Requirements
- R1: While `rst` is high, and on the cycle after it, `rd_data_o` is 0x0000 and `irq_o` is 0.
- R2: A `sent_ack_i` pulse on bit i sets status bit i at the next clock edge. Bit index i = 8*m + c for channel c (0..7) of multiplex m. Multiplex 0 is bits 7..0 and multiplex 1 is bits 15..8.
- R3: An `abort_i` pulse on bit i sets status bit i at the next clock edge.
- R4: `rd_data_o` always shows the status word. A cycle with `rd_en_i` high returns that value and clears the status word at the clock edge ending the cycle.
- R5: An event that arrives in the same cycle as a clearing read leaves its bit set after the read.
- R6: Without a read, set bits stay set.
- R7: After `word_load_i` bit i, channel i's timer counts the cycles in which `tick_i` is high. On the edge that closes the TIMEOUT_TICKS-th such cycle, with no acknowledge or abort in between, status bit i is set if `tmo_en_i` is 1.
- R8: A timer expiry while `tmo_en_i` is 0 does not change the status word.
- R9: An acknowledge or abort stops that channel's timer, so no timeout follows until the next load.
- R10: A new load restarts the channel's count from zero, including a load that comes in the same cycle as a tick.
- R11: `irq_o` equals, one cycle later, the OR of all status bits ANDed with `irq_en_i`.
- R12: While `irq_en_i` is 0, `irq_o` is 0 on the next cycle, whatever the status word holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Clock-enable tick for the timeout timers |
| word_load_i | input | 16 | Per-channel pulse: a word was loaded, so the timer restarts |
| sent_ack_i | input | 16 | Per-channel pulse: the word was sent and pre-acknowledged |
| abort_i | input | 16 | Per-channel pulse: the remote receiver aborted |
| tmo_en_i | input | 1 | 1 lets a timer expiry set its status bit |
| rd_en_i | input | 1 | Read strobe; clears the status word at the edge |
| rd_data_o | output | 16 | Current status word |
| irq_en_i | input | 1 | Summary interrupt enable (0 masks it) |
| irq_o | output | 1 | Registered summary interrupt |

## Verification
The bench builds the block with TIMEOUT_TICKS set to 4, while the channel layout is left at its defaults of two multiplexes of eight. With the short expiry, the timeout path and its collisions with loads, acknowledges, aborts and clearing reads all occur within a few cycles. Random streams of loads, ticks and events then reach expiry often enough to cover those cases many times over. Ticks arrive both every cycle and sparsely, so both the tick gating and the restart on load are exercised.

// File: rtl/mic_pkg.sv
package mic_pkg;

    localparam int MUX_COUNT   = 2;
    localparam int CH_PER_MUX  = 8;
    localparam int CH_TOTAL    = MUX_COUNT * CH_PER_MUX;

    typedef struct packed {
        logic sent;
        logic abort;
        logic tmo;
    } ch_event_t;

    typedef enum logic {
        TMR_IDLE = 1'b0,
        TMR_RUN  = 1'b1
    } tmr_state_e;

    function automatic int chan_bit(input int mux, input int ch);
        return mux * CH_PER_MUX + ch;
    endfunction

    function automatic logic event_sets(input ch_event_t ev, input logic tmo_en);
        return ev.sent | ev.abort | (ev.tmo & tmo_en);
    endfunction

endpackage

// File: rtl/mic_ch_timer.sv
module mic_ch_timer
    import mic_pkg::*;
#(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic load,
    input  logic stop,
    output logic expire
);
    localparam int CNT_W = (LIMIT > 1) ? $clog2(LIMIT) : 1;

    tmr_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             at_end;

    assign at_end = (cnt_q == CNT_W'(LIMIT - 1));
    assign expire = (state_q == TMR_RUN) && tick && !load && at_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= TMR_IDLE;
            cnt_q   <= '0;
        end else if (load) begin
            state_q <= TMR_RUN;
            cnt_q   <= '0;
        end else if (stop || expire) begin
            state_q <= TMR_IDLE;
            cnt_q   <= '0;
        end else if (state_q == TMR_RUN && tick) begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/mic_status_reg.sv
module mic_status_reg #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_vec,
    input  logic         rd_clr,
    output logic [N-1:0] status_o
);
    logic [N-1:0] status_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
        end else if (rd_clr) begin
            status_q <= set_vec;
        end else begin
            status_q <= status_q | set_vec;
        end
    end

    assign status_o = status_q;
endmodule

// File: rtl/mic_irq_out.sv
module mic_irq_out #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] status,
    input  logic         enable,
    output logic         irq
);
    logic irq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= (|status) & enable;
        end
    end

    assign irq = irq_q;
endmodule

// File: rtl/mon_irq_collector.sv
module mon_irq_collector
    import mic_pkg::*;
#(
    parameter int TIMEOUT_TICKS = 1000
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick_i,
    input  logic [CH_TOTAL-1:0] word_load_i,
    input  logic [CH_TOTAL-1:0] sent_ack_i,
    input  logic [CH_TOTAL-1:0] abort_i,
    input  logic                tmo_en_i,
    input  logic                rd_en_i,
    output logic [CH_TOTAL-1:0] rd_data_o,
    input  logic                irq_en_i,
    output logic                irq_o
);
    ch_event_t           ev   [CH_TOTAL];
    logic [CH_TOTAL-1:0] expire;
    logic [CH_TOTAL-1:0] set_vec;
    logic [CH_TOTAL-1:0] status;

    for (genvar m = 0; m < MUX_COUNT; m++) begin : g_mux
        for (genvar c = 0; c < CH_PER_MUX; c++) begin : g_ch
            localparam int IDX = m * CH_PER_MUX + c;

            mic_ch_timer #(.LIMIT(TIMEOUT_TICKS)) u_tmr (
                .clk    (clk),
                .rst    (rst),
                .tick   (tick_i),
                .load   (word_load_i[IDX]),
                .stop   (sent_ack_i[IDX] | abort_i[IDX]),
                .expire (expire[IDX])
            );

            always_comb begin
                ev[IDX].sent  = sent_ack_i[IDX];
                ev[IDX].abort = abort_i[IDX];
                ev[IDX].tmo   = expire[IDX];
                set_vec[IDX]  = event_sets(ev[IDX], tmo_en_i);
            end
        end
    end

    mic_status_reg #(.N(CH_TOTAL)) u_stat (
        .clk      (clk),
        .rst      (rst),
        .set_vec  (set_vec),
        .rd_clr   (rd_en_i),
        .status_o (status)
    );

    mic_irq_out #(.N(CH_TOTAL)) u_irq (
        .clk    (clk),
        .rst    (rst),
        .status (status),
        .enable (irq_en_i),
        .irq    (irq_o)
    );

    assign rd_data_o = status;
endmodule

// File: rtl/mic_checker.sv
module mic_checker #(
    parameter int N = 16
) (
    input logic         clk,
    input logic         rst,
    input logic [N-1:0] sent_ack_i,
    input logic [N-1:0] abort_i,
    input logic         tmo_en_i,
    input logic         rd_en_i,
    input logic [N-1:0] rd_data_o,
    input logic         irq_en_i,
    input logic         irq_o
);
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (rd_data_o == '0) && !irq_o); // R1

    AST_EVENT_SETS_BIT: assert property (@(posedge clk) disable iff (rst)
        ((sent_ack_i | abort_i) != '0) |=>
        ((rd_data_o & $past(sent_ack_i | abort_i)) == $past(sent_ack_i | abort_i))); // R5

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (rd_en_i && sent_ack_i == '0 && abort_i == '0 && !tmo_en_i) |=> (rd_data_o == '0)); // R4

    AST_STICKY_BITS: assert property (@(posedge clk) disable iff (rst)
        !rd_en_i |=> ((rd_data_o & $past(rd_data_o)) == $past(rd_data_o))); // R6

    AST_TMO_GATED: assert property (@(posedge clk) disable iff (rst)
        (!tmo_en_i && !rd_en_i && sent_ack_i == '0 && abort_i == '0) |=> $stable(rd_data_o)); // R8

    AST_IRQ_RAISED: assert property (@(posedge clk) disable iff (rst)
        (irq_en_i && rd_data_o != '0) |=> irq_o); // R11

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
        !irq_en_i |=> !irq_o); // R12
endmodule

bind mon_irq_collector mic_checker #(.N(mic_pkg::CH_TOTAL)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .sent_ack_i (sent_ack_i),
    .abort_i    (abort_i),
    .tmo_en_i   (tmo_en_i),
    .rd_en_i    (rd_en_i),
    .rd_data_o  (rd_data_o),
    .irq_en_i   (irq_en_i),
    .irq_o      (irq_o)
);

// File: tb/sim_mon_irq_collector.sv
module sim_mon_irq_collector;
    localparam int N   = 16;
    localparam int LIM = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         tick_i = 1'b0;
    logic [N-1:0] word_load_i = '0;
    logic [N-1:0] sent_ack_i = '0;
    logic [N-1:0] abort_i = '0;
    logic         tmo_en_i = 1'b0;
    logic         rd_en_i = 1'b0;
    logic [N-1:0] rd_data_o;
    logic         irq_en_i = 1'b0;
    logic         irq_o;

    int n_chk = 0;
    int n_bad = 0;

    logic [N-1:0] m_stat = '0;
    logic         m_irq  = 1'b0;
    logic [N-1:0] m_run  = '0;
    int           m_cnt [N];

    always #2 clk = ~clk;

    mon_irq_collector #(.TIMEOUT_TICKS(LIM)) u0 (
        .clk(clk), .rst(rst), .tick_i(tick_i), .word_load_i(word_load_i),
        .sent_ack_i(sent_ack_i), .abort_i(abort_i), .tmo_en_i(tmo_en_i),
        .rd_en_i(rd_en_i), .rd_data_o(rd_data_o), .irq_en_i(irq_en_i), .irq_o(irq_o)
    );

    task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [N-1:0] expiry_vec();
        logic [N-1:0] e = '0;
        for (int i = 0; i < N; i++)
            e[i] = m_run[i] && tick_i && !word_load_i[i] && (m_cnt[i] == LIM - 1);
        return e;
    endfunction

    // advance one cycle: model next state from driven inputs, then compare
    task automatic cyc(input string tag);
        logic [N-1:0] e;
        logic [N-1:0] nstat;
        logic         nirq;
        e     = expiry_vec();
        nstat = (rd_en_i ? '0 : m_stat) | sent_ack_i | abort_i | (tmo_en_i ? e : '0);
        nirq  = (|m_stat) & irq_en_i;
        for (int i = 0; i < N; i++) begin
            if (word_load_i[i]) begin
                m_run[i] = 1'b1; m_cnt[i] = 0;
            end else if (sent_ack_i[i] || abort_i[i] || e[i]) begin
                m_run[i] = 1'b0; m_cnt[i] = 0;
            end else if (m_run[i] && tick_i) begin
                m_cnt[i] = m_cnt[i] + 1;
            end
        end
        @(posedge clk);
        @(negedge clk);
        m_stat = nstat;
        m_irq  = nirq;
        check({tag, " status"}, rd_data_o, m_stat);
        check("R11 summary", {15'd0, irq_o}, {15'd0, m_irq});
    endtask

    task automatic idle_inputs();
        word_load_i = '0; sent_ack_i = '0; abort_i = '0; rd_en_i = 1'b0; tick_i = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < N; i++) m_cnt[i] = 0;
        #100000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd7));
        repeat (3) @(negedge clk);
        check("R1 reset status", rd_data_o, '0);
        check("R1 reset irq", {15'd0, irq_o}, '0);
        rst = 1'b0;
        cyc("R1");
        check("R1 after reset", rd_data_o, '0);

        // R2: multiplex 1, channel 3 -> bit 11
        sent_ack_i = 16'h0800; cyc("R2"); idle_inputs();
        check("R2 index", rd_data_o, 16'h0800);
        // R4: read shows value then clears
        rd_en_i = 1'b1;
        check("R4 read value", rd_data_o, 16'h0800);
        cyc("R4"); idle_inputs();
        check("R4 cleared", rd_data_o, 16'h0000);
        // R3 and R6
        abort_i = 16'h0020; cyc("R3"); idle_inputs();
        check("R3 abort", rd_data_o, 16'h0020);
        cyc("R6"); cyc("R6"); cyc("R6");
        check("R6 sticky", rd_data_o, 16'h0020);
        // R5: event coincident with read
        rd_en_i = 1'b1; sent_ack_i = 16'h0004; cyc("R5"); idle_inputs();
        check("R5 kept", rd_data_o, 16'h0004);
        rd_en_i = 1'b1; cyc("R4"); idle_inputs();
        // R7: timeout on channel 7, tick each cycle
        tmo_en_i = 1'b1;
        word_load_i = 16'h0080; cyc("R7"); idle_inputs();
        tick_i = 1'b1;
        repeat (LIM - 1) cyc("R7");
        check("R7 not yet", rd_data_o, 16'h0000);
        cyc("R7");
        check("R7 expired", rd_data_o, 16'h0080);
        tick_i = 1'b0; rd_en_i = 1'b1; cyc("R4"); idle_inputs();
        // R8: timeouts disabled, multiplex 1 channel 1
        tmo_en_i = 1'b0;
        word_load_i = 16'h0200; cyc("R8"); idle_inputs();
        tick_i = 1'b1; repeat (LIM + 2) cyc("R8"); tick_i = 1'b0;
        check("R8 gated", rd_data_o, 16'h0000);
        tmo_en_i = 1'b1;
        // R9: acknowledge stops timer
        word_load_i = 16'h0002; cyc("R9"); idle_inputs();
        tick_i = 1'b1; cyc("R9"); cyc("R9");
        sent_ack_i = 16'h0002; cyc("R9"); sent_ack_i = '0;
        rd_en_i = 1'b1; cyc("R9"); rd_en_i = 1'b0;
        repeat (LIM + 2) cyc("R9"); tick_i = 1'b0;
        check("R9 stopped", rd_data_o, 16'h0000);
        // R10: reload restarts count, load coincides with tick
        word_load_i = 16'h0010; cyc("R10"); idle_inputs();
        tick_i = 1'b1; repeat (LIM - 1) cyc("R10");
        word_load_i = 16'h0010; cyc("R10"); word_load_i = '0;
        repeat (LIM - 1) cyc("R10");
        check("R10 restarted", rd_data_o, 16'h0000);
        cyc("R10");
        check("R10 expired", rd_data_o, 16'h0010);
        tick_i = 1'b0;
        // R11 / R12
        irq_en_i = 1'b1; cyc("R11");
        check("R11 raised", {15'd0, irq_o}, 16'd1);
        irq_en_i = 1'b0; cyc("R12");
        check("R12 masked", {15'd0, irq_o}, 16'd0);
        rd_en_i = 1'b1; irq_en_i = 1'b1; cyc("R4"); rd_en_i = 1'b0;
        cyc("R11");
        check("R11 idle", {15'd0, irq_o}, 16'd0);

        // random phase
        for (int k = 0; k < 4000; k++) begin
            logic dense;
            dense = (k < 2000);
            for (int i = 0; i < N; i++) begin
                word_load_i[i] = ($urandom_range(0, 11) == 0);
                sent_ack_i[i]  = ($urandom_range(0, 29) == 0);
                abort_i[i]     = ($urandom_range(0, 59) == 0);
            end
            tick_i   = dense ? ($urandom_range(0, 3) != 0) : ($urandom_range(0, 4) == 0);
            rd_en_i  = ($urandom_range(0, 5) == 0);
            tmo_en_i = ($urandom_range(0, 7) != 0);
            irq_en_i = ($urandom_range(0, 5) != 0);
            cyc("R2/R3/R5/R7/R9/R10 random");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule